// File: doc/BRIEF.md
# Event-Interval Oscillator Trim Controller

This block checks an on-chip oscillator against an external event stream whose period is known, such as a mains-derived pulse. A free-running timestamp counter advances on every cycle of the local clock. The block takes event edges in pairs. On the first rising edge of a pair it stores the counter value. On the second rising edge it subtracts the stored value from the current count, which gives the number of local clock cycles between the two edges.

The measured interval is compared with an expected cycle count and a tolerance, both supplied on input ports. An interval that is too long means the oscillator runs fast, so the trim code steps down by one. An interval that is too short means it runs slow, so the trim code steps up by one. An interval inside the band leaves the code alone. The trim code drives the oscillator's frequency adjust. A one-cycle strobe marks each new interval.

Top module: `period_trim_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `trim_o` equals the parameter TRIM_INIT, `interval_o` is 0 and `valid_o` is 0.
- R2: `interval_o` equals the number of clock cycles between the rising edges of `evt_i` that open and close a pair. Both edges pass through the same two-flop synchronizer, so its latency cancels out.
- R3: The subtraction is modulo 2^CNT_W. An interval shorter than 2^CNT_W cycles is reported correctly even when the timestamp counter wraps between the two edges.
- R4: `valid_o` is high for exactly one cycle per completed pair. `interval_o` and `trim_o` take their new values in that same cycle, and they hold their values whenever `valid_o` is low.
- R5: If the interval is greater than `expected_i + tol_i`, `trim_o` decreases by one.
- R6: If `tol_i < expected_i` and the interval is less than `expected_i - tol_i`, `trim_o` increases by one. If `tol_i >= expected_i`, no interval counts as too short.
- R7: If the interval lies in the inclusive band [`expected_i - tol_i`, `expected_i + tol_i`], `trim_o` does not change.
- R8: `trim_o` saturates. A decrement at 0 leaves it at 0, and an increment at all-ones leaves it at all-ones.
- R9: The edges alternate roles. The first rising edge of a pair produces no strobe, and the edge after a completed pair opens a new pair.
- R10: Only rising edges of `evt_i` take timestamps. The time at which `evt_i` falls, and how long it stays high, have no effect on the interval. To be seen, `evt_i` must stay high for at least 2 cycles and low for at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Asynchronous external event of known period |
| expected_i | input | CNT_W | Expected number of cycles between paired edges |
| tol_i | input | CNT_W | Allowed deviation from `expected_i` in either direction |
| trim_o | output | TRIM_W | Oscillator trim code |
| interval_o | output | CNT_W | Most recent measured interval |
| valid_o | output | 1 | One-cycle strobe when a new interval is available |

## Verification
The bench measures intervals equal to the expected count, intervals on both band edges, and intervals one cycle outside each edge. Together these separate a hold from a step up or a step down, and they catch an off-by-one at the band limits. It also uses a tolerance larger than the expected count, to show that the clamped lower bound never causes an increment. Runs of intervals that are too long and too short drive the trim code into both limits, which tells saturation apart from wrap-around. Back-to-back long intervals with a narrow counter force a timestamp wrap inside a pair, and a lone edge followed by a late partner shows that pairing restarts after each result. A second edge with a long high time shows that the falling edge has no effect.

// File: rtl/ptrim_pkg.sv
package ptrim_pkg;

    typedef enum logic {
        ARM_FIRST  = 1'b0,
        ARM_SECOND = 1'b1
    } meas_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/ptrim_edge_sync.sv
module ptrim_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ptrim_stamp_counter.sv
module ptrim_stamp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/ptrim_band_judge.sv
module ptrim_band_judge import ptrim_pkg::*; #(
    parameter int W = 16
) (
    input  logic [W-1:0] interval_i,
    input  logic [W-1:0] expected_i,
    input  logic [W-1:0] tol_i,
    output step_e        step_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] upper;
    logic [W-1:0]  lower;
    logic          has_lower;
    logic          too_long;
    logic          too_short;

    always_comb begin
        upper     = {1'b0, expected_i} + {1'b0, tol_i};
        has_lower = expected_i > tol_i;
        lower     = expected_i - tol_i;
        too_long  = {1'b0, interval_i} > upper;
        too_short = has_lower && (interval_i < lower);
        if (too_long)       step_o = STEP_DOWN;
        else if (too_short) step_o = STEP_UP;
        else                step_o = STEP_HOLD;
    end
endmodule

// File: rtl/period_trim_ctrl.sv
module period_trim_ctrl import ptrim_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int TRIM_W      = 6,
    parameter int TRIM_INIT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic [CNT_W-1:0]  expected_i,
    input  logic [CNT_W-1:0]  tol_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic [CNT_W-1:0]  interval_o,
    output logic              valid_o
);
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
    localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_INIT);

    typedef struct packed {
        meas_state_e       st;
        logic [CNT_W-1:0]  first;
        logic [CNT_W-1:0]  intv;
        logic [TRIM_W-1:0] trim;
        logic              valid;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             rise;
    logic [CNT_W-1:0] stamp;
    logic [CNT_W-1:0] elapsed;
    step_e            step;

    ptrim_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_i),
        .rise_o  (rise)
    );

    ptrim_stamp_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (stamp)
    );

    // modulo-2^CNT_W difference: one wrap between edges is harmless
    assign elapsed = stamp - r_q.first;

    ptrim_band_judge #(.W(CNT_W)) u_judge (
        .interval_i (elapsed),
        .expected_i (expected_i),
        .tol_i      (tol_i),
        .step_o     (step)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (rise) begin
            if (r_q.st == ARM_FIRST) begin
                r_d.first = stamp;
                r_d.st    = ARM_SECOND;
            end else begin
                r_d.intv  = elapsed;
                r_d.valid = 1'b1;
                r_d.st    = ARM_FIRST;
                unique case (step)
                    STEP_UP:   if (r_q.trim != TRIM_MAX) r_d.trim = r_q.trim + 1'b1;
                    STEP_DOWN: if (r_q.trim != '0)       r_d.trim = r_q.trim - 1'b1;
                    default:   r_d.trim = r_q.trim;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ARM_FIRST;
            r_q.first <= '0;
            r_q.intv  <= '0;
            r_q.trim  <= TRIM_RST;
            r_q.valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trim_o     = r_q.trim;
    assign interval_o = r_q.intv;
    assign valid_o    = r_q.valid;
endmodule

// File: rtl/period_trim_chk.sv
module period_trim_chk #(
    parameter int CNT_W  = 16,
    parameter int TRIM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TRIM_W-1:0] trim_o,
    input logic [CNT_W-1:0]  interval_o,
    input logic              valid_o
);
    localparam logic [TRIM_W-1:0] TMAX = '1;

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_trim_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(trim_o));

    p_intv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(interval_o));

    p_trim_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (trim_o == $past(trim_o) || trim_o == $past(trim_o) + 1'b1
                     || trim_o == $past(trim_o) - 1'b1));

    p_trim_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(trim_o) == '0) |-> trim_o != TMAX);

    p_trim_ceil_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(trim_o) == TMAX) |-> trim_o != '0);
endmodule

bind period_trim_ctrl period_trim_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trim_o     (trim_o),
    .interval_o (interval_o),
    .valid_o    (valid_o)
);

// File: tb/sim_period_trim_ctrl.sv
module sim_period_trim_ctrl;
    localparam int CW = 10;
    localparam int TW = 4;
    localparam int TI = 8;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt = 1'b0;
    logic [CW-1:0] expv = '0;
    logic [CW-1:0] tolv = '0;
    logic [TW-1:0] trim;
    logic [CW-1:0] intv;
    logic          valid;

    int checks = 0;
    int fails = 0;
    int model_trim = TI;

    always #5ns clk = ~clk;

    period_trim_ctrl #(.CNT_W(CW), .TRIM_W(TW), .TRIM_INIT(TI)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .expected_i(expv),
        .tol_i(tolv), .trim_o(trim), .interval_o(intv), .valid_o(valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expd);
        end
    endtask

    function automatic int predict(input int n, input int cur);
        int e = int'(expv);
        int t = int'(tolv);
        if (n > e + t) return (cur > 0) ? cur - 1 : 0;
        if (e > t && n < e - t) return (cur < TMAX) ? cur + 1 : TMAX;
        return cur;
    endfunction

    // first rising edge: high 3 cycles, then low until gap cycles after the rise
    task automatic rise_first(input int gap, inout int nv);
        evt = 1'b1;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (i == 2) evt = 1'b0;
            if (valid) nv++;
        end
    endtask

    task automatic rise_second(input int hi, inout int nv, output int gi, output int gt);
        evt = 1'b1;
        gi = -1; gt = -1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == hi - 1) evt = 1'b0;
            if (valid) begin
                nv++;
                gi = int'(intv);
                gt = int'(trim);
            end
        end
    endtask

    task automatic pair_check(input int gap, input int hi, input string req);
        int nv = 0;
        int gi, gt;
        rise_first(gap, nv);
        rise_second(hi, nv, gi, gt);
        model_trim = predict(gap, model_trim);
        chk(nv == 1, "R4", {req, " strobe count"}, nv, 1);
        chk(gi == gap, "R2", {req, " interval"}, gi, gap);
        chk(gt == model_trim, req, "trim after pair", gt, model_trim);
    endtask

    task automatic t_reset;
        chk(trim == TI, "R1", "trim in reset", int'(trim), TI);
        chk(intv == 0, "R1", "interval in reset", int'(intv), 0);
        chk(valid == 0, "R1", "valid in reset", int'(valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(trim == TI && valid == 0, "R1", "state after release", int'(trim), TI);
    endtask

    task automatic t_band;
        expv = 10'd100; tolv = 10'd5;
        pair_check(100, 3, "R7");
        pair_check(105, 3, "R7");
        pair_check(95, 3, "R7");
        pair_check(106, 3, "R5");
        pair_check(94, 3, "R6");
        repeat (5) @(negedge clk);
        chk(int'(intv) == 94, "R4", "interval held", int'(intv), 94);
        chk(int'(trim) == model_trim, "R4", "trim held", int'(trim), model_trim);
    endtask

    task automatic t_wide_tol;
        expv = 10'd4; tolv = 10'd10;
        pair_check(8, 3, "R6");
    endtask

    task automatic t_falling_edge;
        expv = 10'd60; tolv = 10'd3;
        pair_check(60, 12, "R10");
        pair_check(50, 14, "R10");
    endtask

    task automatic t_alternate;
        int nv = 0;
        int gi, gt;
        expv = 10'd300; tolv = 10'd400;
        rise_first(20, nv);
        chk(nv == 0, "R9", "no strobe on opening edge", nv, 0);
        repeat (27) @(negedge clk);
        rise_second(3, nv, gi, gt);
        chk(nv == 1, "R9", "strobe on closing edge", nv, 1);
        chk(gi == 47, "R9", "interval of late partner", gi, 47);
        pair_check(30, 3, "R9");
    endtask

    task automatic t_wrap;
        expv = 10'd700; tolv = 10'd10;
        pair_check(700, 3, "R3");
        pair_check(712, 3, "R3");
        pair_check(688, 3, "R3");
        pair_check(1000, 3, "R3");
    endtask

    task automatic t_saturate;
        expv = 10'd20; tolv = 10'd2;
        for (int k = 0; k < TMAX + 2; k++) pair_check(40, 3, "R8");
        chk(int'(trim) == 0, "R8", "floor", int'(trim), 0);
        for (int k = 0; k < TMAX + 2; k++) pair_check(10, 3, "R8");
        chk(int'(trim) == TMAX, "R8", "ceiling", int'(trim), TMAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_band();
        t_wide_tol();
        t_falling_edge();
        t_alternate();
        t_wrap();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule